// File: doc/BRIEF.md
# Serial Register-Access Slave with Selectable Wire Count and Bit Order

This block is a serial slave that lets a host read and write a bank of 32 eight-bit registers over a four-signal serial link. The link has an active-low select, a serial clock, a data line split into input, output and output-enable for a tristate pad, and a second serial output with its own enable. Every transaction opens with one instruction byte. That byte carries the direction, how many data bytes follow (one to four) and a 5-bit register address. The data bytes come straight after it.

Register 0 is the link's own control register. One bit moves read data from the shared data line onto the separate output pin (4-wire operation). Another bit flips the bit order of the whole transaction to least-significant-first. The bit order also sets the direction in which the register address steps during a multibyte access. Both settings are captured when the select falls, so a write to register 0 governs the next transaction and not the one carrying it. The serial pins are oversampled in the system clock domain. This keeps the block fully synchronous, with registered outputs.

Top module: `cfg_spi_slave`

## Requirements
- R1: The first eight bits after the select falls form the instruction byte. Its fields are given for the byte read most significant bit first: bit 7 is direction (1 = read, 0 = write), bits 6:5 are the count (00, 01, 10, 11 give 1, 2, 3, 4 data bytes), and bits 4:0 are the register address.
- R2: Input bits are sampled on the rising serial-clock edge. Data bytes follow the instruction byte with no gap. A register is written only once all eight bits of its byte have arrived.
- R3: When register 0 bit 6 is 0, bits travel most significant first. The first data byte uses the header address, and each further byte uses the previous address minus one, wrapping from 0 to 31.
- R4: When register 0 bit 6 is 1, the instruction byte and the data bytes travel least significant first. Each further byte uses the previous address plus one, wrapping from 31 to 0.
- R5: Register 0 bit 7 selects 4-wire operation and bit 6 selects least-significant-first order. Both reset to 0. Register 0 bits 5:0 always read as 0. A new register 0 value first applies to the transaction that starts after it was written.
- R6: With 4-wire operation off, read data is driven on `sdio_out` with `sdio_oe` high during every read data bit, and `sdo_oe` stays low.
- R7: With 4-wire operation on, read data is driven on `sdo` with `sdo_oe` high during every read data bit, and `sdio_oe` stays low for the whole transaction.
- R8: Both output enables are low during the instruction byte, during write data, after the last counted byte, and whenever the select is high.
- R9: Read data bits change only after a falling serial-clock edge, so each bit is valid at the host's next rising edge.
- R10: If the select rises partway through a byte, that partial byte is dropped and nothing is written. The next falling edge of the select starts a fresh instruction byte.
- R11: A synchronous active-high reset clears register 0 and drives both output enables low.
- R12: Serial clocks beyond the counted bytes are ignored. No register is written and no output is driven until the select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low transaction select |
| sdio_in | input | 1 | Shared data line, input side |
| sdio_out | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line, pad drive enable |
| sdo | output | 1 | Separate serial data output |
| sdo_oe | output | 1 | Separate serial output drive enable |

## Verification
The bench targets the following corner cases, and each one exposes a particular fault:
- Multibyte accesses that cross the 0/31 boundary in both directions. A design that steps the wrong way, or fails to wrap, returns bytes from the wrong registers.
- Transactions that write register 0 while it is also part of the access. A design that switches bit order or pin mid-transaction garbles the following bytes.
- Transactions cut short by the select rising partway through a byte. These would corrupt a register if the partial byte were committed.
- Trailing clocks after the counted bytes. These would overwrite a neighbouring register, or keep a pad driven, if the byte count were not enforced.

In every read, the output enables are checked on both pins so that read data lands on exactly one pin.

// File: rtl/xspi_pkg.sv
package xspi_pkg;
  localparam int XSPI_AW = 5;
  localparam int XSPI_DW = 8;
  localparam int XSPI_CW = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_WR,
    PH_RD,
    PH_DONE
  } xspi_phase_e;
endpackage

// File: rtl/xspi_pin_sync.sv
module xspi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic cs_act_o,
  output logic cs_start_o,
  output logic sdi_o
);
  localparam int NSIG = 3;
  localparam int IDX_CS = 1;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic sclk_d, csn_d;

  assign raw = {sdi_i, cs_n_i, sclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= (g == IDX_CS) ? '1 : '0;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      csn_d      <= 1'b1;
      rise_o     <= 1'b0;
      fall_o     <= 1'b0;
      cs_act_o   <= 1'b0;
      cs_start_o <= 1'b0;
      sdi_o      <= 1'b0;
    end else begin
      sclk_d     <= synced[0];
      csn_d      <= synced[IDX_CS];
      rise_o     <= synced[0] & ~sclk_d;
      fall_o     <= ~synced[0] & sclk_d;
      cs_act_o   <= ~synced[IDX_CS];
      cs_start_o <= ~synced[IDX_CS] & csn_d;
      sdi_o      <= synced[2];
    end
  end
endmodule

// File: rtl/xspi_regfile.sv
module xspi_regfile #(
  parameter int AW         = 5,
  parameter int DW         = 8,
  parameter int LSB_BIT    = 6,
  parameter int FOURW_BIT  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          cfg_lsb_o,
  output logic          cfg_4w_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          lsb_q, fourw_q;
  logic [DW-1:0] ctrl_word;

  always_ff @(posedge clk) begin
    if (wr_en_i && wr_addr_i != '0) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lsb_q   <= 1'b0;
      fourw_q <= 1'b0;
    end else if (wr_en_i && wr_addr_i == '0) begin
      lsb_q   <= wr_data_i[LSB_BIT];
      fourw_q <= wr_data_i[FOURW_BIT];
    end
  end

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[LSB_BIT]   = lsb_q;
    ctrl_word[FOURW_BIT] = fourw_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                  rd_data_o <= '0;
    else if (rd_addr_i == '0) rd_data_o <= ctrl_word;
    else                      rd_data_o <= mem[rd_addr_i];
  end

  assign cfg_lsb_o = lsb_q;
  assign cfg_4w_o  = fourw_q;

  AST_CTRL_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr_i == '0) |-> (rd_data_o[5:0] == '0)); // R5
  AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == '0) |=> (cfg_lsb_o == $past(wr_data_i[LSB_BIT]))); // R5
endmodule

// File: rtl/xspi_engine.sv
module xspi_engine import xspi_pkg::*; #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          cs_act_i,
  input  logic          cs_start_i,
  input  logic          sdi_i,
  input  logic          cfg_lsb_i,
  input  logic          cfg_4w_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          tx_bit_o,
  output logic          sdio_oe_o,
  output logic          sdo_oe_o
);
  localparam int BCW = $clog2(DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  xspi_phase_e    phase_q;
  logic [BCW-1:0] bit_cnt_q;
  logic [DW-1:0]  sh_q, nxt, tx_sh_q;
  logic [AW-1:0]  addr_q, step;
  logic [CW-1:0]  left_q;
  logic           lsb_q, w4_q;

  assign nxt  = lsb_q ? {sdi_i, sh_q[DW-1:1]} : {sh_q[DW-2:0], sdi_i};
  assign step = lsb_q ? AW'(addr_q + 1'b1) : AW'(addr_q - 1'b1);
  assign rd_addr_o = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_sh_q   <= '0;
      addr_q    <= '0;
      left_q    <= '0;
      lsb_q     <= 1'b0;
      w4_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      tx_bit_o  <= 1'b0;
      sdio_oe_o <= 1'b0;
      sdo_oe_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (!cs_act_i) begin
        phase_q   <= PH_IDLE;
        bit_cnt_q <= '0;
        sdio_oe_o <= 1'b0;
        sdo_oe_o  <= 1'b0;
      end else if (cs_start_i) begin
        phase_q   <= PH_HDR;
        bit_cnt_q <= '0;
        lsb_q     <= cfg_lsb_i;
        w4_q      <= cfg_4w_i;
      end else if (rise_i) begin
        case (phase_q)
          PH_HDR: begin
            sh_q      <= nxt;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) begin
              left_q  <= nxt[DW-2 -: CW];
              addr_q  <= nxt[AW-1:0];
              phase_q <= nxt[DW-1] ? PH_RD : PH_WR;
            end
          end
          PH_WR: begin
            sh_q      <= nxt;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= addr_q;
              wr_data_o <= nxt;
              addr_q    <= step;
              left_q    <= left_q - 1'b1;
              if (left_q == '0) phase_q <= PH_DONE;
            end
          end
          PH_RD: begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) begin
              addr_q <= step;
              left_q <= left_q - 1'b1;
              if (left_q == '0) begin
                phase_q   <= PH_DONE;
                sdio_oe_o <= 1'b0;
                sdo_oe_o  <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end else if (fall_i && phase_q == PH_RD) begin
        if (bit_cnt_q == '0) begin
          tx_bit_o  <= lsb_q ? rd_data_i[0] : rd_data_i[DW-1];
          tx_sh_q   <= lsb_q ? (rd_data_i >> 1) : (rd_data_i << 1);
          sdio_oe_o <= !w4_q;
          sdo_oe_o  <= w4_q;
        end else begin
          tx_bit_o <= lsb_q ? tx_sh_q[0] : tx_sh_q[DW-1];
          tx_sh_q  <= lsb_q ? (tx_sh_q >> 1) : (tx_sh_q << 1);
        end
      end
    end
  end

  AST_WR_AFTER_FULL_BYTE: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> ($past(rise_i) && $past(cs_act_i))); // R2
  AST_ADDR_DEC: assert property (@(posedge clk) disable iff (rst)
    (cs_act_i && !cs_start_i && rise_i && (phase_q == PH_WR || phase_q == PH_RD)
     && bit_cnt_q == LAST_BIT && left_q != '0 && !lsb_q)
    |=> (addr_q == AW'($past(addr_q) - 1'b1))); // R3
  AST_ADDR_INC: assert property (@(posedge clk) disable iff (rst)
    (cs_act_i && !cs_start_i && rise_i && (phase_q == PH_WR || phase_q == PH_RD)
     && bit_cnt_q == LAST_BIT && left_q != '0 && lsb_q)
    |=> (addr_q == AW'($past(addr_q) + 1'b1))); // R4
  AST_OE_ONE_PIN: assert property (@(posedge clk) disable iff (rst)
    !(sdio_oe_o && sdo_oe_o)); // R6
  AST_4W_SDIO_INPUT: assert property (@(posedge clk) disable iff (rst)
    w4_q |-> !sdio_oe_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cs_act_i |=> (!sdio_oe_o && !sdo_oe_o)); // R8
  AST_BIT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_bit_o) |-> $past(fall_i)); // R9
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave import xspi_pkg::*; #(
  parameter int AW          = XSPI_AW,
  parameter int DW          = XSPI_DW,
  parameter int CW          = XSPI_CW,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_clk,
  input  logic spi_cs_n,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo,
  output logic sdo_oe
);
  logic          rise, fall, cs_act, cs_start, sdi_s;
  logic          cfg_lsb, cfg_4w;
  logic [DW-1:0] rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          wr_en, tx_bit;

  xspi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(spi_clk), .cs_n_i(spi_cs_n), .sdi_i(sdio_in),
    .rise_o(rise), .fall_o(fall), .cs_act_o(cs_act), .cs_start_o(cs_start), .sdi_o(sdi_s)
  );

  xspi_engine #(.AW(AW), .DW(DW), .CW(CW)) u_engine (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .cs_act_i(cs_act),
    .cs_start_i(cs_start), .sdi_i(sdi_s), .cfg_lsb_i(cfg_lsb), .cfg_4w_i(cfg_4w),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .tx_bit_o(tx_bit), .sdio_oe_o(sdio_oe), .sdo_oe_o(sdo_oe)
  );

  xspi_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cfg_lsb_o(cfg_lsb), .cfg_4w_o(cfg_4w)
  );

  assign sdio_out = tx_bit;
  assign sdo      = tx_bit;
endmodule

// File: tb/cfg_spi_slave_tb_top.sv
module cfg_spi_slave_tb_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_clk = 1'b0, spi_cs_n = 1'b1, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo, sdo_oe;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;
  logic [7:0] mdl [32];
  logic [7:0] wbuf [4];

  always #2 clk = ~clk;

  cfg_spi_slave dut_i (
    .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_cs_n(spi_cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  function automatic logic [7:0] stored(input logic [4:0] a, input logic [7:0] d);
    return (a == 5'd0) ? (d & 8'hC0) : d;
  endfunction

  task automatic shift_bit(input logic b, input logic w4, output logic line,
                           output logic soe, output logic doe);
    @(negedge clk);
    sdio_in = b;
    repeat (H - 1) @(negedge clk);
    line = w4 ? sdo : sdio_out;
    soe  = sdio_oe;
    doe  = sdo_oe;
    spi_clk = 1'b1;
    repeat (H) @(negedge clk);
    spi_clk = 1'b0;
  endtask

  task automatic xfer(input bit rw, input int n, input logic [4:0] a, input int extra,
                      input string tag);
    logic lsb, w4, line, soe, doe;
    logic [7:0] hdr, got, wd;
    logic [4:0] cur;
    bit bad;
    lsb = mdl[0][6];
    w4  = mdl[0][7];
    hdr = {rw, 2'(n - 1), a};
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      shift_bit(lsb ? hdr[i] : hdr[7-i], w4, line, soe, doe);
      if (soe || doe) bad = 1;
    end
    chk(!bad, "R8 enables during header", bad, 0);
    cur = a;
    for (int k = 0; k < n; k++) begin
      bad = 0;
      if (!rw) begin
        wd = wbuf[k];
        for (int i = 0; i < 8; i++) begin
          shift_bit(lsb ? wd[i] : wd[7-i], w4, line, soe, doe);
          if (soe || doe) bad = 1;
        end
        mdl[cur] = stored(cur, wd);
        chk(!bad, "R8 enables during write data", bad, 0);
      end else begin
        got = '0;
        for (int i = 0; i < 8; i++) begin
          shift_bit(1'b0, w4, line, soe, doe);
          got[lsb ? i : 7-i] = line;
          if (soe !== !w4 || doe !== w4) bad = 1;
        end
        chk(got === mdl[cur], tag, got, mdl[cur]);
        chk(!bad, w4 ? "R7 read pin enables" : "R6 read pin enables", bad, 0);
      end
      cur = lsb ? cur + 5'd1 : cur - 5'd1;
    end
    if (extra > 0) begin
      bad = 0;
      for (int i = 0; i < extra; i++) begin
        shift_bit(1'($urandom), w4, line, soe, doe);
        if (soe || doe) bad = 1;
      end
      chk(!bad, "R12 trailing clocks drive nothing", bad, 0);
    end
    repeat (H) @(negedge clk);
    chk(!sdio_oe && !sdo_oe, "R8 enables after last byte", {sdio_oe, sdo_oe}, 0);
    spi_cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
    chk(!sdio_oe && !sdo_oe, "R8 enables with select high", {sdio_oe, sdo_oe}, 0);
  endtask

  task automatic cut_short(input logic [15:0] word, input int nbits);
    logic line, soe, doe;
    logic lsb;
    lsb = mdl[0][6];
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i < 8) shift_bit(lsb ? word[8+i] : word[15-i], mdl[0][7], line, soe, doe);
      else       shift_bit(lsb ? word[i-8] : word[15-i], mdl[0][7], line, soe, doe);
    end
    spi_cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic wr1(input logic [4:0] a, input logic [7:0] d);
    wbuf[0] = d;
    xfer(1'b0, 1, a, 0, "R2");
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errs++;
    vecs++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240917);
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(!sdio_oe && !sdo_oe, "R11 enables low in reset", {sdio_oe, sdo_oe}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!sdio_oe && !sdo_oe, "R11 enables low after reset", {sdio_oe, sdo_oe}, 0);
    xfer(1'b1, 1, 5'd0, 0, "R11 control register reset value");

    // Fill every register with 4-byte MSB-first writes (R1, R3); reg 0 gets 0x3F.
    for (int g = 7; g >= 0; g--) begin
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      if (g == 0) wbuf[3] = 8'h3F;
      xfer(1'b0, 4, 5'(g * 4 + 3), 0, "R1");
    end
    xfer(1'b1, 1, 5'd0, 0, "R5 low control bits read zero");
    xfer(1'b1, 4, 5'd2, 0, "R3 decrement wraps 0 to 31");
    xfer(1'b1, 3, 5'd17, 0, "R1 three-byte count");
    xfer(1'b1, 2, 5'd9, 0, "R1 two-byte count");

    // Switch to LSB-first within an MSB-first transfer touching regs 1 and 0.
    wbuf[0] = 8'hA5; wbuf[1] = 8'h40;
    xfer(1'b0, 2, 5'd1, 0, "R5");
    xfer(1'b1, 4, 5'd30, 0, "R4 increment wraps 31 to 0");
    for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
    xfer(1'b0, 4, 5'd12, 0, "R4");
    xfer(1'b1, 4, 5'd12, 0, "R4 LSB-first write readback");

    // 4-wire, LSB-first, then 4-wire MSB-first.
    wr1(5'd0, 8'hC0);
    xfer(1'b1, 4, 5'd20, 0, "R7 4-wire LSB-first read");
    wr1(5'd0, 8'h80);
    xfer(1'b1, 3, 5'd1, 0, "R7 4-wire MSB-first read");
    wr1(5'd0, 8'h00);
    xfer(1'b1, 1, 5'd0, 0, "R5 control back to zero");

    // Trailing clocks past the count must not write the next register.
    wbuf[0] = 8'h5A;
    xfer(1'b0, 1, 5'd7, 8, "R12");
    xfer(1'b1, 3, 5'd7, 0, "R12 neighbours untouched");

    // Select rises mid-byte: partial data byte dropped, then mid-header.
    cut_short({8'b0_00_01011, 8'hFF}, 12);
    xfer(1'b1, 1, 5'd11, 0, "R10 partial byte not written");
    cut_short({8'b1_11_00011, 8'h00}, 3);
    xfer(1'b1, 1, 5'd11, 0, "R10 new header after abort");

    for (int t = 0; t < 110; t++) begin
      bit rw;
      int n, extra;
      logic [4:0] a;
      rw = 1'($urandom);
      n  = 1 + ($urandom % 4);
      a  = 5'($urandom);
      extra = (($urandom % 8) == 0) ? 1 + ($urandom % 7) : 0;
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      xfer(rw, n, a, extra, "R9 random read data");
    end
    for (int i = 0; i < 8; i++) xfer(1'b1, 4, 5'(i * 4 + 3), 0, "R2 final sweep");
    report();
  end
endmodule